// File: doc/BRIEF.md
# Wrapping Linear Burst Read Engine

This block is the read-side controller of a synchronous 32-bit memory. A small configuration register picks one of two modes. In single-access mode each read returns one word. In burst mode a read streams words out of an aligned group of 2, 4 or 8 words, and the initial latency can be set from 2 to 16 clocks. The burst may start at any word of the group. It climbs to the top of the group, wraps back to the group's first word, and keeps repeating as long as the clock runs and chip enable stays low.

A host starts an access by holding chip enable and address valid low across a rising clock edge. A region select routes the access to one of four places: the main array, a 64-word special sector, the configuration register, or a fixed protection word. The two register regions always answer as single held reads. The engine flags the beat just before each wrap on an indicator pin, marks good beats with a data-valid output, and drops everything the moment chip enable rises. The storage behind it is a plain synchronous RAM model with a preload write port.

Top module: `wburst_engine`

## Requirements
- R1: While reset is low and in the first cycle after it, `dq_oe`, `dvalid` and `ind_oe` are 0 and `ind_n` is 1. The configuration register resets to 0, which selects single-access mode, length 2 and latency 2.
- R2: A write with `cfg_we` high stores `cfg_wdata[6:0]` at the next edge. Bit 0 enables burst mode. Bits 2:1 set the length: 0 gives 2 words, 1 gives 4, and 2 or 3 give 8. Bits 6:3 hold the latency minus 2, and codes 14 and 15 both mean 16 clocks. Reading region 2 returns the 7 stored bits with zeros above them.
- R3: A burst starts at the rising edge where `ce_n` and `adv_n` are both low, in region 0 or 1, with burst mode on. That edge latches the address. Counting it as edge 1, the first beat shows after edge L, where L is the latency. `dvalid` stays 0 in the cycles before that beat.
- R4: Beats run from the start offset `addr mod len` and step by one modulo the length inside the aligned group. After the last offset they wrap back to the start offset and repeat.
- R5: `ind_oe` is high during the latency and data phases of a burst. `ind_n` is 0 exactly on the beat whose offset is (start offset − 1) mod len, and 1 on every other beat.
- R6: When `ce_n` is high, `dq_oe`, `dvalid` and `ind_oe` are 0 in the same cycle. After that no data is driven again until `ce_n` and `adv_n` are both low at an edge.
- R7: If `adv_n` goes low during a burst, the old address is dropped. `dvalid` is 0 through the new latency, and then the new address's sequence follows.
- R8: With burst mode off, an array read presents its word after the start edge with `dvalid` high. The word stays unchanged over any number of further clocks.
- R9: Region encodings are 0 array, 1 sector, 2 configuration, 3 protection. Reads of region 2 or 3 show their value after the start edge and hold it, even with burst mode on. Region 3 reads 32'h00005A3C.
- R10: Region 1 maps word address w to sector word `w[5:0]`. A sector access with w ≥ 64 drives beats with `dvalid` 0.
- R11: `oe_n` high forces `dq_oe` to 0 at once. It does not affect the burst sequence or `dvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 7 | Configuration value |
| mem_we | input | 1 | RAM preload write strobe |
| mem_waddr | input | 9 | RAM preload index (bit 8 selects the sector) |
| mem_wdata | input | 32 | RAM preload data |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 8 | Word address |
| rgn | input | 2 | Region select |
| dq | output | 32 | Read data |
| dq_oe | output | 1 | Data bus drive enable |
| dvalid | output | 1 | Current beat carries good data |
| ind_n | output | 1 | Last-beat-before-wrap indicator, active low |
| ind_oe | output | 1 | Indicator drive enable |

## Verification
Each result falls due at a known point, counted from the start edge, which is edge 1:
- Register reads and single array reads are due right after edge 1.
- The first burst beat is due after edge L.
- Each later beat follows one edge after the one before it.
- The abort on `ce_n` and the gating by `oe_n` take effect in the same cycle, with no edge in between.

The bench drives its inputs and samples the outputs at falling edges. For the immediate effects it samples 1 ns after the input changes. Each scenario task walks the clock edge by edge. It checks that `dvalid` is low on every latency cycle before it checks the data beats.

// File: rtl/wburst_pkg.sv
// Package: shared encodings and widths of the wrapping burst read engine.
// Assumes: offsets inside a burst group never exceed 3 bits (8 words).
package wburst_pkg;

    localparam int OFF_W   = 3;   // offset width inside the largest group
    localparam int CFG_W   = 7;   // configuration register width
    localparam int LAT_W   = 4;   // latency field width
    localparam int LAT_MAX = 14;  // largest latency-minus-2 accepted
    localparam int SECT_W  = 6;   // sector size in word-address bits

    typedef enum logic [1:0] {
        RG_ARRAY  = 2'd0,
        RG_SECTOR = 2'd1,
        RG_CFG    = 2'd2,
        RG_PROT   = 2'd3
    } rgn_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_DATA   = 2'd2,
        ST_SINGLE = 2'd3
    } seq_e;

endpackage

// File: rtl/wburst_cfg.sv
// Module: configuration register of the burst engine.
// Holds the mode, the length code and the latency code, and decodes them
// into a burst enable, a group mask and a clamped latency count.
// Assumes: writes are single-cycle strobes and take effect at the next edge.
module wburst_cfg
    import wburst_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_word,
    output logic                 burst_en,
    output logic [OFF_W-1:0]     len_mask,
    output logic [LAT_W-1:0]     lat_m2
);

    logic [CFG_W-1:0] cfg_q;
    logic [LAT_W-1:0] lat_raw;

    // Store the configuration word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_we)
            cfg_q <= cfg_wdata;
    end

    // Decode the stored fields into the controls the sequencer needs.
    always_comb begin
        burst_en = cfg_q[0];
        case (cfg_q[2:1])
            2'd0:    len_mask = 3'b001;
            2'd1:    len_mask = 3'b011;
            default: len_mask = 3'b111;
        endcase
        lat_raw = cfg_q[6:3];
        lat_m2  = (lat_raw > LAT_W'(LAT_MAX)) ? LAT_W'(LAT_MAX) : lat_raw;
        cfg_word = cfg_q;
    end

    AST_LAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we) |-> (lat_m2 <= LAT_W'(LAT_MAX)) && (cfg_word == $past(cfg_wdata))); // R2

endmodule

// File: rtl/wburst_ram.sv
// Module: synchronous RAM model behind the engine.
// Holds one read register loaded every edge from the read index, plus a
// preload write port. The upper half of the index space holds the sector.
// Assumes: reads and writes to the same index in one cycle return old data.
module wburst_ram #(
    parameter int IW = 9,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << IW;

    logic [DW-1:0] mem [DEPTH];

    // Preload write into the storage array.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Registered read of the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= mem[raddr];
    end

endmodule

// File: rtl/wburst_seq.sv
// Module: burst sequencer.
// Latches the start address and region, counts out the latency, steps the
// beat offset around the aligned group, and raises the pre-wrap indicator.
// Single accesses (single-access mode or register regions) park in a hold
// state. Assumes: the RAM read register adds one edge, so the read index
// always points at the word that is due after the next edge.
module wburst_seq
    import wburst_pkg::*;
#(
    parameter int AW = 8,
    parameter int IW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic [AW-1:0]     addr,
    input  logic [1:0]        rgn,
    input  logic              burst_en,
    input  logic [OFF_W-1:0]  len_mask,
    input  logic [LAT_W-1:0]  lat_m2,
    output logic [IW-1:0]     rd_idx,
    output seq_e              st_o,
    output rgn_e              rgn_o,
    output logic              dv_o,
    output logic              ind_n_o
);

    seq_e             st_q;
    rgn_e             rgn_q;
    rgn_e             rgn_in;
    logic [AW-1:0]    base_q;
    logic [OFF_W-1:0] mask_q;
    logic [OFF_W-1:0] soff_q;
    logic [OFF_W-1:0] off_q;
    logic [LAT_W-1:0] cnt_q;
    logic             dv_q;
    logic             ind_q;
    logic             start;
    logic             is_mem;
    logic [OFF_W-1:0] nxt_off;
    logic [OFF_W-1:0] nxt2_off;
    logic [OFF_W-1:0] st_off;
    logic [AW-1:0]    w_cur;
    logic [AW-1:0]    w_nxt;

    // Map a word address in a region onto the RAM index space.
    function automatic logic [IW-1:0] ram_index(input logic [AW-1:0] w, input rgn_e rg);
        if (rg == RG_SECTOR)
            return {1'b1, {(AW-SECT_W){1'b0}}, w[SECT_W-1:0]};
        else
            return {1'b0, w};
    endfunction

    // A sector word address is good only inside the first 64 words.
    function automatic logic word_ok(input logic [AW-1:0] w, input rgn_e rg);
        return (rg != RG_SECTOR) || (w[AW-1:SECT_W] == '0);
    endfunction

    // Replace the low bits of a group address with an offset.
    function automatic logic [AW-1:0] place(input logic [AW-1:0] b,
                                            input logic [OFF_W-1:0] m,
                                            input logic [OFF_W-1:0] o);
        return (b & ~{{(AW-OFF_W){1'b0}}, m}) | {{(AW-OFF_W){1'b0}}, o};
    endfunction

    // Decode the start strobe and the offsets around the current beat.
    always_comb begin
        rgn_in   = rgn_e'(rgn);
        start    = !ce_n && !adv_n;
        is_mem   = (rgn_in == RG_ARRAY) || (rgn_in == RG_SECTOR);
        st_off   = addr[OFF_W-1:0] & len_mask;
        nxt_off  = (off_q + OFF_W'(1)) & mask_q;
        nxt2_off = (nxt_off + OFF_W'(1)) & mask_q;
        w_cur    = place(base_q, mask_q, off_q);
        w_nxt    = place(base_q, mask_q, nxt_off);
    end

    // Point the RAM at the word due after the next edge.
    always_comb begin
        if (start)
            rd_idx = ram_index(addr, rgn_in);
        else if (st_q == ST_DATA)
            rd_idx = ram_index(w_nxt, rgn_q);
        else
            rd_idx = ram_index(w_cur, rgn_q);
    end

    // Main state, address, offset and latency bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            rgn_q  <= RG_ARRAY;
            base_q <= '0;
            mask_q <= '0;
            soff_q <= '0;
            off_q  <= '0;
            cnt_q  <= '0;
            dv_q   <= 1'b0;
            ind_q  <= 1'b1;
        end else if (start) begin
            rgn_q  <= rgn_in;
            base_q <= addr;
            mask_q <= len_mask;
            soff_q <= st_off;
            off_q  <= st_off;
            ind_q  <= 1'b1;
            if (is_mem && burst_en) begin
                st_q  <= ST_WAIT;
                cnt_q <= lat_m2;
                dv_q  <= 1'b0;
            end else begin
                st_q  <= ST_SINGLE;
                dv_q  <= word_ok(addr, rgn_in);
            end
        end else if (ce_n) begin
            st_q  <= ST_IDLE;
            dv_q  <= 1'b0;
            ind_q <= 1'b1;
        end else begin
            case (st_q)
                ST_WAIT: begin
                    if (cnt_q == '0) begin
                        st_q  <= ST_DATA;
                        dv_q  <= word_ok(w_cur, rgn_q);
                        ind_q <= (nxt_off != soff_q);
                    end else begin
                        cnt_q <= cnt_q - LAT_W'(1);
                    end
                end
                ST_DATA: begin
                    off_q <= nxt_off;
                    dv_q  <= word_ok(w_nxt, rgn_q);
                    ind_q <= (nxt2_off != soff_q);
                end
                default: ;
            endcase
        end
    end

    assign st_o    = st_q;
    assign rgn_o   = rgn_q;
    assign dv_o    = dv_q;
    assign ind_n_o = ind_q;

    AST_CE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n) |=> (st_q == ST_IDLE) && !dv_q); // R6
    AST_OFF_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA) |-> ((off_q & ~mask_q) == '0)); // R4
    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_DATA) && $past(st_q == ST_DATA) && !$past(start) && !$past(ce_n))
        |-> (off_q == (($past(off_q) + OFF_W'(1)) & mask_q))); // R4
    AST_WAIT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT) |-> !dv_q); // R3
    AST_IND_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !ind_q |-> (st_q == ST_DATA)); // R5
    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SINGLE) && $past(st_q == ST_SINGLE) && !$past(start))
        |-> ($stable(base_q) && $stable(rgn_q))); // R9

endmodule

// File: rtl/wburst_engine.sv
// Module: top of the wrapping linear burst read engine.
// Ties the configuration register, the sequencer and the RAM model together
// and forms the output bus, its drive enable and the indicator enable.
// Assumes: all host inputs are synchronous to clk. Chip enable and output
// enable act on the drive enables combinationally.
module wburst_engine
    import wburst_pkg::*;
#(
    parameter int          AW        = 8,
    parameter int          DW        = 32,
    parameter logic [31:0] PROT_WORD = 32'h0000_5A3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              mem_we,
    input  logic [AW:0]       mem_waddr,
    input  logic [DW-1:0]     mem_wdata,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic              oe_n,
    input  logic [AW-1:0]     addr,
    input  logic [1:0]        rgn,
    output logic [DW-1:0]     dq,
    output logic              dq_oe,
    output logic              dvalid,
    output logic              ind_n,
    output logic              ind_oe
);

    localparam int IW = AW + 1;

    logic [CFG_W-1:0] cfg_word;
    logic             burst_en;
    logic [OFF_W-1:0] len_mask;
    logic [LAT_W-1:0] lat_m2;
    logic [IW-1:0]    rd_idx;
    logic [DW-1:0]    rd_data;
    seq_e             st;
    rgn_e             rgn_q;
    logic             dv;
    logic             ind_q;
    logic             active;

    wburst_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_word  (cfg_word),
        .burst_en  (burst_en),
        .len_mask  (len_mask),
        .lat_m2    (lat_m2)
    );

    wburst_seq #(.AW(AW), .IW(IW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .adv_n    (adv_n),
        .addr     (addr),
        .rgn      (rgn),
        .burst_en (burst_en),
        .len_mask (len_mask),
        .lat_m2   (lat_m2),
        .rd_idx   (rd_idx),
        .st_o     (st),
        .rgn_o    (rgn_q),
        .dv_o     (dv),
        .ind_n_o  (ind_q)
    );

    wburst_ram #(.IW(IW), .DW(DW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_idx),
        .rdata (rd_data)
    );

    // Select the read source and form the drive enables.
    always_comb begin
        case (rgn_q)
            RG_CFG:  dq = {{(DW-CFG_W){1'b0}}, cfg_word};
            RG_PROT: dq = PROT_WORD;
            default: dq = rd_data;
        endcase
        active = (st == ST_DATA) || (st == ST_SINGLE);
        dq_oe  = !ce_n && !oe_n && active;
        dvalid = !ce_n && dv;
        ind_oe = !ce_n && ((st == ST_WAIT) || (st == ST_DATA));
        ind_n  = ind_q;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !dvalid && !ind_oe && ind_n); // R1
    AST_DV_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ce_n) && ce_n) |-> !dq_oe && !dvalid); // R6
    AST_PROT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn_q == RG_PROT) && (st == ST_SINGLE) |-> (dq == PROT_WORD)); // R9

endmodule

// File: tb/tb_wburst_engine.sv
// Directed bench for the wrapping burst read engine: one task per scenario,
// each checking its own results at falling edges.
module tb_wburst_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [6:0]  cfg_wdata;
    logic        mem_we;
    logic [8:0]  mem_waddr;
    logic [31:0] mem_wdata;
    logic        ce_n, adv_n, oe_n;
    logic [7:0]  addr;
    logic [1:0]  rgn;
    logic [31:0] dq;
    logic        dq_oe, dvalid, ind_n, ind_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    wburst_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n), .addr(addr), .rgn(rgn),
        .dq(dq), .dq_oe(dq_oe), .dvalid(dvalid), .ind_n(ind_n), .ind_oe(ind_oe)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] arr_word(input int i);
        return 32'hA000_0000 | 32'(i);
    endfunction
    function automatic logic [31:0] sec_word(input int i);
        return 32'h5EC0_0000 | 32'(i);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [6:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    // Start an access: ce_n and adv_n low across one edge, then adv_n high.
    task automatic begin_access(input logic [1:0] rg, input int a);
        ce_n = 1'b0; adv_n = 1'b0; addr = 8'(a); rgn = rg;
        tick();
        adv_n = 1'b1;
    endtask

    // Run a burst, check latency-cycle silence, then every beat and indicator.
    task automatic run_burst(input string req, input logic [1:0] rg, input int a,
                             input int len, input int lat, input int beats,
                             input logic exp_dv);
        int so, base;
        so = a % len;
        base = a - so;
        begin_access(rg, a);
        for (int i = 0; i < lat - 1; i++) begin
            chk({req, " latency dvalid"}, 32'(dvalid), 32'd0);
            chk({req, " latency ind_oe"}, 32'(ind_oe), 32'd1);
            tick();
        end
        for (int b = 0; b < beats; b++) begin
            int off, w;
            off = (so + b) % len;
            w = base + off;
            chk({req, " beat data"}, dq, (rg == 2'd1) ? sec_word(w & 63) : arr_word(w));
            chk({req, " beat dvalid"}, 32'(dvalid), 32'(exp_dv));
            chk({"R5 ", req, " indicator"}, 32'(ind_n),
                (off == (so + len - 1) % len) ? 32'd0 : 32'd1);
            if (b != beats - 1) tick();
        end
    endtask

    task automatic t_reset();
        chk("R1 dq_oe", 32'(dq_oe), 32'd0);
        chk("R1 dvalid", 32'(dvalid), 32'd0);
        chk("R1 ind_oe", 32'(ind_oe), 32'd0);
        chk("R1 ind_n", 32'(ind_n), 32'd1);
        begin_access(2'd2, 0);
        chk("R1 cfg reset value", dq, 32'd0);
        ce_n = 1'b1; tick();
    endtask

    task automatic t_preload();
        for (int i = 0; i < 512; i++) begin
            mem_we = 1'b1; mem_waddr = 9'(i);
            mem_wdata = (i >= 256) ? sec_word(i & 63) : arr_word(i);
            tick();
        end
        mem_we = 1'b0;
    endtask

    task automatic t_cfg_readback();
        write_cfg({4'd9, 2'd3, 1'b1});
        begin_access(2'd2, 0);
        chk("R2 cfg readback", dq, 32'h4F);
        ce_n = 1'b1; tick();
    endtask

    task automatic t_bursts();
        write_cfg({4'd0, 2'd1, 1'b1});           // len 4, latency 2
        run_burst("R3 R4 len4 off2", 2'd0, 34, 4, 2, 9, 1'b1);
        ce_n = 1'b1; tick();
        write_cfg({4'd3, 2'd2, 1'b1});           // len 8, latency 5
        run_burst("R4 len8 off5", 2'd0, 77, 8, 5, 10, 1'b1);
        ce_n = 1'b1; tick();
        write_cfg({4'd15, 2'd0, 1'b1});          // len 2, latency clamp 16
        run_burst("R2 R3 clamp len2", 2'd0, 9, 2, 16, 4, 1'b1);
        ce_n = 1'b1; tick();
        write_cfg({4'd3, 2'd3, 1'b1});           // code 3 length is 8
        run_burst("R2 len code3", 2'd0, 130, 8, 5, 3, 1'b1);
        ce_n = 1'b1; tick();
    endtask

    task automatic t_abort();
        write_cfg({4'd0, 2'd2, 1'b1});
        run_burst("R6 pre-abort", 2'd0, 0, 8, 2, 3, 1'b1);
        ce_n = 1'b1;
        #1;
        chk("R6 dq_oe drop", 32'(dq_oe), 32'd0);
        chk("R6 dvalid drop", 32'(dvalid), 32'd0);
        chk("R6 ind_oe drop", 32'(ind_oe), 32'd0);
        tick();
        ce_n = 1'b0;
        tick(); tick();
        chk("R6 no data without start", 32'(dq_oe), 32'd0);
        chk("R6 no dvalid without start", 32'(dvalid), 32'd0);
        ce_n = 1'b1; tick();
    endtask

    task automatic t_restart();
        write_cfg({4'd2, 2'd1, 1'b1});           // len 4, latency 4
        run_burst("R7 first", 2'd0, 16, 4, 4, 2, 1'b1);
        tick();
        run_burst("R7 restarted", 2'd0, 35, 4, 4, 5, 1'b1);
        ce_n = 1'b1; tick();
    endtask

    task automatic t_async();
        write_cfg({4'd6, 2'd2, 1'b0});
        begin_access(2'd0, 40);
        for (int i = 0; i < 10; i++) begin
            chk("R8 single held data", dq, arr_word(40));
            chk("R8 single dvalid", 32'(dvalid), 32'd1);
            tick();
        end
        ce_n = 1'b1; tick();
    endtask

    task automatic t_regs_in_burst();
        write_cfg({4'd4, 2'd1, 1'b1});
        begin_access(2'd3, 0);
        for (int i = 0; i < 8; i++) begin
            chk("R9 protection held", dq, 32'h0000_5A3C);
            chk("R9 protection dvalid", 32'(dvalid), 32'd1);
            tick();
        end
        ce_n = 1'b1; tick();
        begin_access(2'd2, 0);
        for (int i = 0; i < 8; i++) begin
            chk("R9 cfg held in burst mode", dq, 32'h23);
            tick();
        end
        ce_n = 1'b1; tick();
    endtask

    task automatic t_sector();
        write_cfg({4'd1, 2'd1, 1'b1});           // len 4, latency 3
        run_burst("R10 sector in range", 2'd1, 10, 4, 3, 5, 1'b1);
        ce_n = 1'b1; tick();
        run_burst("R10 sector past end", 2'd1, 70, 4, 3, 3, 1'b0);
        ce_n = 1'b1; tick();
    endtask

    task automatic t_oe();
        write_cfg({4'd0, 2'd1, 1'b1});
        run_burst("R11 before oe", 2'd0, 4, 4, 2, 2, 1'b1);
        oe_n = 1'b1;
        #1;
        chk("R11 dq_oe off", 32'(dq_oe), 32'd0);
        chk("R11 dvalid kept", 32'(dvalid), 32'd1);
        tick();
        chk("R11 sequence continues", dq, arr_word(6));
        oe_n = 1'b0;
        #1;
        chk("R11 dq_oe back", 32'(dq_oe), 32'd1);
        ce_n = 1'b1; tick();
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; mem_we = 1'b0;
        mem_waddr = '0; mem_wdata = '0; ce_n = 1'b1; adv_n = 1'b1;
        oe_n = 1'b0; addr = '0; rgn = '0;
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        t_reset();
        t_preload();
        t_cfg_readback();
        t_bursts();
        t_abort();
        t_restart();
        t_async();
        t_regs_in_burst();
        t_sector();
        t_oe();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule